// File: doc/BRIEF.md
# Local Bus Memory Target

This block is the slave side of a 32-bit local bus in the style of the 486 processor bus. In the clock after a low address strobe it decodes the cycle type and the word address. When the cycle is a memory access that falls inside its configured window, it claims the cycle by pulling its local-device output low. It then completes the cycle in one of two ways. A single transfer ends with one local-ready strobe. A burst has four data beats, and each beat ends with a burst-ready strobe.

The storage behind the bus is a word-wide register file inside the block. It has a write strobe per byte lane and an asynchronous read port. Writes take the bus data at the clock edge that ends a ready cycle. Reads drive the stored word on a separate output bus, qualified by an enable, while the ready is low. A parameter sets the number of wait states inserted before every ready. A second parameter makes the block report itself as a 16-bit target for the whole of each cycle it claims.

Top module: `lbus_target`

## Requirements
- R1: While reset is high, and in the cycle after reset is released, ldev_n, lrdy_n, brdy_n and lbs16_n are all 1, data_oe is 0 and data_out is 0. Reset also clears every stored word to zero.
- R2: The block claims a cycle when ads_n is 0 at a rising edge with the block idle, the type {mio,dc,wr} is 100 (code fetch), 110 (memory read) or 111 (memory write), and addr_w[29:IDX] equals BASE_ADDR[31:IDX+2]. When it claims, ldev_n is 0 from the next cycle through the cycle of the final ready.
- R3: The block does not claim a cycle whose address is outside the window, nor one of type 000, 001, 010, 011 or 101. For such a cycle ldev_n stays 1 and the stored contents do not change.
- R4: A claimed cycle with blast_n=1 at the strobe is a single transfer. lrdy_n is 0 for exactly one cycle and brdy_n stays 1.
- R5: A claimed cycle with blast_n=0 at the strobe is a burst. brdy_n is 0 for exactly four beats and lrdy_n stays 1. Beat k accesses word (A[3:2]+k) mod 4 of the 16-byte block that holds start address A.
- R6: On a write, stored byte i (bits 8i+7:8i) takes wdata at the edge that ends each ready cycle only if be_n[i] is 0. The be_n captured at the strobe applies to every beat.
- R7: During each ready cycle of a read or code fetch, data_oe is 1 and data_out holds the word being accessed. At all other times data_oe is 0 and data_out is 0.
- R8: For WAIT_STATES=W, each beat (and each single transfer) has W cycles without a ready, followed by one ready cycle. The first ready is in cycle W+1 after the strobe edge.
- R9: In the cycle after the final ready, every bus output is inactive again. A strobe sampled in that cycle starts a new cycle.
- R10: ads_n and rdyrtn_n sampled while a cycle is in progress have no effect on that cycle or on the stored data.
- R11: With SIZE16=1, lbs16_n is 0 exactly while ldev_n is 0. With SIZE16=0, lbs16_n is always 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local bus clock |
| rst | input | 1 | Synchronous reset, active high |
| ads_n | input | 1 | Address strobe, active low |
| addr_w | input | 30 | Word address (byte address bits 31:2) |
| be_n | input | 4 | Byte lane enables, active low |
| mio | input | 1 | Memory (1) or I/O (0) cycle |
| dc | input | 1 | Data (1) or command (0) cycle |
| wr | input | 1 | Write (1) or read (0) |
| blast_n | input | 1 | Low at the strobe marks a four-beat burst |
| rdyrtn_n | input | 1 | Early ready return from the controller |
| wdata | input | 32 | Write data from the bus |
| ldev_n | output | 1 | Cycle claimed, active low |
| lrdy_n | output | 1 | Single transfer done, active low |
| brdy_n | output | 1 | Burst beat done, active low |
| lbs16_n | output | 1 | 16-bit target indication, active low |
| data_out | output | 32 | Read data |
| data_oe | output | 1 | Read data valid / drive enable |

## Verification
A sequencer whose wait counter or beat index is corrupted shows up at the ports within one beat. The ready strobe moves by some cycles, the ready is of the wrong kind, or ldev_n is released early or late. A bad capture of the address or lane enables is not visible when it happens. It appears as wrong data_out on a later read of the affected word, so every write is followed by a read of the same words. Strobes issued during a cycle are checked two ways: the sequence in progress must keep its exact timing, and the data of the words they point at must be unchanged.

// File: rtl/lbus_pkg.sv
package lbus_pkg;

    localparam int LANES = 4;
    localparam int BEATS = 4;

    typedef enum logic [2:0] {
        CT_INTA     = 3'b000,
        CT_SPECIAL  = 3'b001,
        CT_IORD     = 3'b010,
        CT_IOWR     = 3'b011,
        CT_FETCH    = 3'b100,
        CT_SHUTDOWN = 3'b101,
        CT_MEMRD    = 3'b110,
        CT_MEMWR    = 3'b111
    } cyc_type_e;

    typedef enum logic {
        ST_IDLE,
        ST_BEAT
    } seq_state_e;

    typedef struct packed {
        logic [LANES-1:0] be_n;
        logic             write;
    } xfer_t;

    function automatic logic claimable(cyc_type_e t);
        return (t == CT_FETCH) || (t == CT_MEMRD) || (t == CT_MEMWR);
    endfunction

    function automatic logic [1:0] beat_word(logic [1:0] start, logic [1:0] beat);
        return start + beat;
    endfunction

endpackage

// File: rtl/lbus_decode.sv
module lbus_decode
    import lbus_pkg::*;
#(
    parameter logic [31:0] BASE_ADDR = 32'h0000_1000,
    parameter int          IDX_W     = 6,
    localparam int         TAG_W     = 30 - IDX_W
) (
    input  logic [TAG_W-1:0] tag,
    input  logic             mio,
    input  logic             dc,
    input  logic             wr,
    output logic             hit,
    output logic             is_write
);
    localparam logic [TAG_W-1:0] BASE_TAG = BASE_ADDR[31:IDX_W+2];

    cyc_type_e ctype;

    always_comb begin
        ctype    = cyc_type_e'({mio, dc, wr});
        hit      = claimable(ctype) && (tag == BASE_TAG);
        is_write = (ctype == CT_MEMWR);
    end
endmodule

// File: rtl/lbus_seq.sv
module lbus_seq
    import lbus_pkg::*;
#(
    parameter int WAIT_STATES = 1,
    localparam int WCW = (WAIT_STATES > 0) ? $clog2(WAIT_STATES + 1) : 1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       burst_in,
    output logic       busy,
    output logic       ready,
    output logic       last,
    output logic       burst_mode,
    output logic [1:0] beat
);
    localparam logic [WCW-1:0] WLAST = WCW'(WAIT_STATES);

    seq_state_e     state;
    logic [WCW-1:0] wcnt;

    always_comb begin
        busy       = (state == ST_BEAT);
        ready      = busy && (wcnt == WLAST);
        last       = ready && (!burst_mode || beat == 2'(BEATS - 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            wcnt       <= '0;
            beat       <= '0;
            burst_mode <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state      <= ST_BEAT;
                        wcnt       <= '0;
                        beat       <= '0;
                        burst_mode <= burst_in;
                    end
                end
                ST_BEAT: begin
                    if (ready) begin
                        if (last) begin
                            state <= ST_IDLE;
                        end else begin
                            beat <= beat + 2'd1;
                            wcnt <= '0;
                        end
                    end else begin
                        wcnt <= wcnt + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R8: wait states ahead of the first ready
    a_r8_first_wait: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (ready == (WAIT_STATES == 0)));

    // R8: wait states between beats of a burst
    a_r8_beat_gap: assert property (@(posedge clk) disable iff (rst)
        (ready && !last) |=> (busy && (ready == (WAIT_STATES == 0))));

    // R9: sequencer idle right after the final ready
    a_r9_release: assert property (@(posedge clk) disable iff (rst)
        last |=> !busy);

    // R4: a single transfer never advances the beat index
    a_r4_single_beat: assert property (@(posedge clk) disable iff (rst)
        (busy && !burst_mode) |-> (beat == 2'd0));
endmodule

// File: rtl/lbus_regfile.sv
module lbus_regfile
    import lbus_pkg::*;
#(
    parameter int WORDS = 64,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  logic [31:0]      wdata,
    input  logic [LANES-1:0] wbe_n,
    output logic [31:0]      rdata
);
    logic [31:0] mem [WORDS];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst) begin
                for (int w = 0; w < WORDS; w++) mem[w][8*g +: 8] <= 8'h00;
            end else if (we && !wbe_n[g]) begin
                mem[idx][8*g +: 8] <= wdata[8*g +: 8];
            end
        end
    end

    assign rdata = mem[idx];
endmodule

// File: rtl/lbus_target.sv
module lbus_target
    import lbus_pkg::*;
#(
    parameter logic [31:0] BASE_ADDR   = 32'h0000_1000,
    parameter int          WIN_WORDS   = 64,
    parameter int          WAIT_STATES = 1,
    parameter bit          SIZE16      = 1'b0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        ads_n,
    input  logic [29:0] addr_w,
    input  logic [3:0]  be_n,
    input  logic        mio,
    input  logic        dc,
    input  logic        wr,
    input  logic        blast_n,
    input  logic        rdyrtn_n,
    input  logic [31:0] wdata,
    output logic        ldev_n,
    output logic        lrdy_n,
    output logic        brdy_n,
    output logic        lbs16_n,
    output logic [31:0] data_out,
    output logic        data_oe
);
    localparam int IDX_W = $clog2(WIN_WORDS);

    logic             hit, is_write, start;
    logic             busy, ready, last, burst_mode;
    logic [1:0]       beat;
    xfer_t            req_q;
    logic [IDX_W-1:0] start_idx, acc_idx;
    logic [31:0]      rdata;
    logic             we;

    lbus_decode #(.BASE_ADDR(BASE_ADDR), .IDX_W(IDX_W)) u_decode (
        .tag(addr_w[29:IDX_W]), .mio(mio), .dc(dc), .wr(wr),
        .hit(hit), .is_write(is_write)
    );

    assign start = !ads_n && !busy && hit;

    lbus_seq #(.WAIT_STATES(WAIT_STATES)) u_seq (
        .clk(clk), .rst(rst), .start(start), .burst_in(!blast_n),
        .busy(busy), .ready(ready), .last(last),
        .burst_mode(burst_mode), .beat(beat)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q     <= '0;
            start_idx <= '0;
        end else if (start) begin
            req_q     <= '{be_n: be_n, write: is_write};
            start_idx <= addr_w[IDX_W-1:0];
        end
    end

    always_comb begin
        acc_idx = (start_idx & ~IDX_W'(3)) | IDX_W'(beat_word(start_idx[1:0], beat));
        we      = ready && req_q.write;
    end

    lbus_regfile #(.WORDS(WIN_WORDS)) u_regs (
        .clk(clk), .rst(rst), .we(we), .idx(acc_idx),
        .wdata(wdata), .wbe_n(req_q.be_n), .rdata(rdata)
    );

    always_comb begin
        ldev_n   = !busy;
        lrdy_n   = !(ready && !burst_mode);
        brdy_n   = !(ready && burst_mode);
        data_oe  = ready && !req_q.write;
        data_out = data_oe ? rdata : 32'h0;
    end

    if (SIZE16) begin : g_size16
        assign lbs16_n = !busy;
    end else begin : g_size32
        assign lbs16_n = 1'b1;
    end

    // R1: every output inactive after a reset cycle
    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (ldev_n && lrdy_n && brdy_n && lbs16_n && !data_oe));

    // R2: no ready of either kind without a claim
    a_r2_ready_claimed: assert property (@(posedge clk) disable iff (rst)
        (!lrdy_n || !brdy_n) |-> !ldev_n);

    // R3: no read drive and no write while unclaimed
    a_r3_no_access_idle: assert property (@(posedge clk) disable iff (rst)
        ldev_n |-> (!data_oe && !we));

    // R10: strobes or ready return during a cycle leave the captured request alone
    a_r10_busy_strobe: assert property (@(posedge clk) disable iff (rst)
        (busy && !ads_n) |=> $stable(req_q));
    a_r10_rdyrtn_early: assert property (@(posedge clk) disable iff (rst)
        (busy && !rdyrtn_n) |=> $stable(start_idx));
endmodule

// File: tb/lbus_target_test.sv
`timescale 1ns/1ps
module lbus_target_test;
    localparam logic [31:0] BASE = 32'h0000_1000;
    localparam int WS = 2;
    localparam int WIN = 64;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ads_n = 1'b1, mio = 1'b0, dc = 1'b0, wr = 1'b0, blast_n = 1'b1, rdyrtn_n = 1'b1;
    logic [29:0] addr_w = '0;
    logic [3:0]  be_n = 4'hF;
    logic [31:0] wdata = 32'h1234_5678;
    logic ldev_n, lrdy_n, brdy_n, lbs16_n, data_oe;
    logic [31:0] data_out;

    int tests = 0, fails = 0;
    bit done = 1'b0;
    string tag = "R1 reset";

    always #4 clk = ~clk;

    lbus_target #(.BASE_ADDR(BASE), .WIN_WORDS(WIN), .WAIT_STATES(WS), .SIZE16(1'b1)) uut (
        .clk(clk), .rst(rst), .ads_n(ads_n), .addr_w(addr_w), .be_n(be_n),
        .mio(mio), .dc(dc), .wr(wr), .blast_n(blast_n), .rdyrtn_n(rdyrtn_n),
        .wdata(wdata), .ldev_n(ldev_n), .lrdy_n(lrdy_n), .brdy_n(brdy_n),
        .lbs16_n(lbs16_n), .data_out(data_out), .data_oe(data_oe)
    );

    // behavioural reference
    bit          m_act, m_burst, m_write;
    int          m_phase, m_beat;
    logic [5:0]  m_start;
    logic [3:0]  m_be;
    logic [31:0] m_mem [WIN];

    function automatic int m_idx();
        return (int'(m_start) & 'h3C) | ((int'(m_start) + m_beat) & 3);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_act = 0; m_phase = 0; m_beat = 0;
            for (int i = 0; i < WIN; i++) m_mem[i] = 32'h0;
        end else if (m_act) begin
            if (m_phase == WS) begin
                if (m_write)
                    for (int b = 0; b < 4; b++)
                        if (!m_be[b]) m_mem[m_idx()][8*b +: 8] = wdata[8*b +: 8];
                if (!m_burst || m_beat == 3) m_act = 0;
                else begin m_beat++; m_phase = 0; end
            end else m_phase++;
        end else if (!ads_n) begin
            if (mio && (dc || !wr) && (addr_w[29:6] == BASE[31:8])) begin
                m_act = 1; m_phase = 0; m_beat = 0;
                m_burst = !blast_n; m_write = dc && wr;
                m_start = addr_w[5:0]; m_be = be_n;
            end
        end
    end

    task automatic chk(string name, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s [%s]: actual %h expected %h", name, tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            bit rdy;
            bit oe;
            rdy = m_act && (m_phase == WS);
            oe  = rdy && !m_write;
            chk("R2 R9 ldev_n", 32'(ldev_n), 32'(!m_act));
            chk("R4 R8 lrdy_n", 32'(lrdy_n), 32'(!(rdy && !m_burst)));
            chk("R5 R8 brdy_n", 32'(brdy_n), 32'(!(rdy && m_burst)));
            chk("R11 lbs16_n", 32'(lbs16_n), 32'(!m_act));
            chk("R7 data_oe", 32'(data_oe), 32'(oe));
            chk("R6 R7 data_out", data_out, oe ? m_mem[m_idx()] : 32'h0);
        end
    end

    always @(negedge clk) wdata <= wdata * 32'd1664525 + 32'd1013904223;

    // called at a falling edge; returns at a falling edge once idle
    task automatic xfer(logic [31:0] a, logic [2:0] ct, bit burst, logic [3:0] be);
        ads_n = 1'b0; addr_w = a[31:2]; {mio, dc, wr} = ct;
        blast_n = !burst; be_n = be;
        @(negedge clk);
        ads_n = 1'b1; blast_n = 1'b1;
        while (m_act) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset ldev_n/lrdy_n/brdy_n/lbs16_n", {ldev_n, lrdy_n, brdy_n, lbs16_n}, 4'hF);
        chk("R1 reset data_oe", 32'(data_oe), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 after release ldev_n", 32'(ldev_n), 1);

        tag = "R4 R6 single full write";
        xfer(32'h1004, 3'b111, 0, 4'h0);
        tag = "R7 single read";
        xfer(32'h1004, 3'b110, 0, 4'h0);
        tag = "R6 lanes 0 and 2";
        xfer(32'h1004, 3'b111, 0, 4'b1010);
        xfer(32'h1004, 3'b110, 0, 4'h0);
        tag = "R5 burst write wrap";
        xfer(32'h1018, 3'b111, 1, 4'h0);
        tag = "R5 burst read wrap";
        xfer(32'h1010, 3'b110, 1, 4'h0);
        tag = "R6 burst lane 3 only";
        xfer(32'h1034, 3'b111, 1, 4'b0111);
        xfer(32'h1030, 3'b110, 1, 4'h0);
        tag = "R2 code fetch";
        xfer(32'h1018, 3'b100, 0, 4'h0);
        tag = "R3 miss and non-memory types";
        xfer(32'h2004, 3'b111, 0, 4'h0);
        xfer(32'h0FFC, 3'b111, 0, 4'h0);
        xfer(32'h1004, 3'b011, 0, 4'h0);
        xfer(32'h1004, 3'b000, 0, 4'h0);
        xfer(32'h1004, 3'b001, 0, 4'h0);
        xfer(32'h1004, 3'b101, 0, 4'h0);
        xfer(32'h1004, 3'b010, 1, 4'h0);
        chk("R3 no claim after ignored types", 32'(ldev_n), 1);
        xfer(32'h1004, 3'b110, 0, 4'h0);
        tag = "R10 strobe and ready return during burst";
        ads_n = 1'b0; addr_w = 30'h1008 >> 2; {mio, dc, wr} = 3'b110; blast_n = 1'b0; be_n = 4'h0;
        @(negedge clk);
        ads_n = 1'b1; blast_n = 1'b1;
        @(negedge clk);
        ads_n = 1'b0; addr_w = 30'h1000 >> 2; {mio, dc, wr} = 3'b111; rdyrtn_n = 1'b0;
        @(negedge clk);
        ads_n = 1'b1; rdyrtn_n = 1'b1;
        while (m_act) @(negedge clk);
        xfer(32'h1000, 3'b110, 1, 4'h0);
        tag = "R9 idle gap then single";
        repeat (3) @(negedge clk);
        xfer(32'h10FC, 3'b111, 0, 4'h0);
        xfer(32'h10FC, 3'b110, 0, 4'h0);
        @(negedge clk);
        chk("R9 outputs inactive after final ready", {ldev_n, lrdy_n, brdy_n, data_oe}, 4'hE);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            fails++;
            tests++;
            $display("FAIL watchdog [%s]: actual hung expected done", tag);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule